// File: doc/BRIEF.md
# Serial Register Access Engine

This block is the target side of a four-wire serial link (clock, select, data in, data out). It runs in mode 0 and is oversampled by a faster system clock. Each transaction opens with an 8-bit header, sent most significant bit first. Bit 7 is the direction (1 = read), bit 6 is the burst flag and bits 5:0 are the address. After the header the engine performs one of four actions:

- a single read or write of a 47-entry configuration file (addresses 0x00–0x2E);
- a streaming burst of such reads or writes;
- a one-cycle command pulse to a neighbouring controller;
- a write of bytes into a neighbouring transmit queue.

While a header shifts in, the engine shifts out a status byte built from live inputs: {not-ready, mode[2:0], queue room[3:0]].

The window 0x30–0x3D has two meanings, chosen by the burst flag. With the flag clear, a header in this window issues a command pulse and carries no data, so another header may follow at once. With the flag set, the header performs a single read of one external status register, using the low four address bits as its index. Address 0x3F, with the flag clear, pushes one byte into the queue. Address 0x3F with the flag set (header 0x7F) streams bytes into the queue until select rises.

The state machine has five states:

- OFF: select is high.
- WAIT: select is low, the core is not ready, and the output is held high.
- HDR: a header byte is shifting in.
- WR: a write data byte is shifting in.
- RD: a read data byte is shifting out.

Its transitions:

- OFF→HDR or OFF→WAIT when select falls, depending on ready.
- WAIT→HDR when ready rises.
- HDR→HDR after a command header.
- HDR→RD after a read header; HDR→WR after a write header.
- WR→HDR and RD→HDR after a single-access byte.
- WR→WR and RD→RD while a burst continues.
- Any state→OFF when select rises.

Top module: `spi_cfg_slave`

## Requirements
- R1: Header bits arrive MSB first; bit 7 = 1 selects read, bit 6 is the burst flag, bits 5:0 the address.
- R2: Addresses 0x00–0x2E hold 8-bit registers, reset to 0x00, that can all be written and read back; reads of 0x2F, 0x3E, 0x3F and of 0x30–0x3D outside a status read return 0x00.
- R3: With the burst flag set, the address advances by one after every data byte until select rises. Without it, exactly one data byte follows and the next byte is a new header.
- R4: If select rises part-way through a byte, that byte is discarded and nothing is committed.
- R5: A header with burst = 0 and an address in 0x30–0x3D raises strobe_valid for exactly one system clock with that address on strobe_addr. The following byte in the same selection is decoded as a header.
- R6: A header with burst = 1 and an address in 0x30–0x3D is a single access. A read returns stat_rdata, with stat_addr = address[3:0]. A write data byte there is ignored: no register, queue or command is affected.
- R7: The status byte is {~core_ready, radio_mode, fifo_room}. It is shifted out during every header and every write data byte. On reads, the register data follows the header.
- R8: sdo_en is low while select is high. With select low and core_ready low, sdo is 1. Once ready, sdo shows status bit 7, which is 0, before the first clock rise.
- R9: Address 0x3F written with burst = 0 pushes one byte on fifo_wvalid/fifo_wdata. With burst = 1, every data byte is pushed and the address does not advance.
- R10: SDI is sampled on rising SCK and SDO changes only after falling SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock (idles low) |
| cs_n | input | 1 | Select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (low = high-impedance) |
| core_ready | input | 1 | Supply and oscillator ready |
| radio_mode | input | 3 | Mode field of status byte |
| fifo_room | input | 4 | Free-space field of status byte |
| stat_addr | output | 4 | Status register index |
| stat_rdata | input | 8 | Status register value for stat_addr |
| strobe_valid | output | 1 | Command pulse |
| strobe_addr | output | 6 | Command address |
| fifo_wvalid | output | 1 | Queue write pulse |
| fifo_wdata | output | 8 | Queue write byte |

## Verification
A wrong bit counter or a stuck state shows within one byte time. The data byte after a header would then come out as status instead of register data, or the other way round. A stray strobe or queue pulse would also appear where none belongs. A burst address counter that fails to advance, or advances when it should not, is exposed by the second byte of a burst read, which returns the wrong register value. A mishandled cancellation only surfaces on a later read-back, which the tests perform straight after each cancelled access.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] CMD_LO    = 6'h30;
    localparam logic [ADDR_W-1:0] CMD_HI    = 6'h3D;
    localparam logic [ADDR_W-1:0] QUEUE_ADR = 6'h3F;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAIT, ST_HDR, ST_WR, ST_RD
    } spi_st_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_s,
    output logic sdi_s
);
    logic [STAGES-1:0] sck_q, cs_q, sdi_q;
    logic              sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            sdi_q <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_q <= {sck_q[STAGES-2:0], sck};
            cs_q  <= {cs_q[STAGES-2:0], cs_n};
            sdi_q <= {sdi_q[STAGES-2:0], sdi};
            sck_d <= sck_q[STAGES-1];
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_q[STAGES-1] & sck_d;
    assign cs_s     = cs_q[STAGES-1];
    assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile #(
    parameter int N  = 47,
    parameter int AW = 6,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem[i] <= '0;
            else if (we && waddr == AW'(i))    mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (raddr == AW'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int CFG_REGS    = 47,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    input  logic              core_ready,
    input  logic [2:0]        radio_mode,
    input  logic [3:0]        fifo_room,
    output logic [3:0]        stat_addr,
    input  logic [DATA_W-1:0] stat_rdata,
    output logic              strobe_valid,
    output logic [ADDR_W-1:0] strobe_addr,
    output logic              fifo_wvalid,
    output logic [DATA_W-1:0] fifo_wdata
);
    localparam logic [ADDR_W-1:0] CFG_LAST = ADDR_W'(CFG_REGS - 1);

    spi_st_e state, state_nxt;
    logic sck_rise, sck_fall, cs_s, sdi_s;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    logic [DATA_W-1:0] tx_sr, tx_next;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q, stat_q;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_waddr, rd_addr;
    logic [DATA_W-1:0] rf_wdata, rf_rdata, rd_val, status_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_s(cs_s), .sdi_s(sdi_s)
    );

    spi_cfg_regfile #(.N(CFG_REGS), .AW(ADDR_W), .W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .raddr(rd_addr), .rdata(rf_rdata)
    );

    // decoded pieces of the byte completing on this edge
    logic [DATA_W-1:0] rx_byte;
    logic              byte_done, h_rw, h_burst, h_cmdwin, cont_burst, active;
    logic [ADDR_W-1:0] h_addr;
    assign rx_byte    = {rx_sr, sdi_s};
    assign h_rw       = rx_byte[7];
    assign h_burst    = rx_byte[6];
    assign h_addr     = rx_byte[5:0];
    assign h_cmdwin   = (h_addr >= CMD_LO) && (h_addr <= CMD_HI);
    assign active     = (state == ST_HDR) || (state == ST_WR) || (state == ST_RD);
    assign byte_done  = active && sck_rise && (bit_cnt == 3'd7);
    assign cont_burst = burst_q && !stat_q;
    assign status_byte = {~core_ready, radio_mode, fifo_room};

    assign rd_addr   = (state == ST_HDR) ? h_addr : addr_q + 1'b1;
    assign stat_addr = rd_addr[3:0];
    assign rd_val    = (state == ST_HDR && h_burst && h_cmdwin) ? stat_rdata : rf_rdata;

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (cs_s) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_WAIT: state_nxt = core_ready ? ST_HDR : ST_WAIT;
                ST_HDR: if (byte_done) begin
                    if (!h_burst && h_cmdwin) state_nxt = ST_HDR;
                    else if (h_rw)            state_nxt = ST_RD;
                    else                      state_nxt = ST_WR;
                end
                ST_WR, ST_RD: if (byte_done && !cont_burst) state_nxt = ST_HDR;
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0; rx_sr <= '0; tx_sr <= '1; tx_next <= '1;
            addr_q <= '0; burst_q <= 1'b0; stat_q <= 1'b0;
            rf_we <= 1'b0; rf_waddr <= '0; rf_wdata <= '0;
            strobe_valid <= 1'b0; strobe_addr <= '0;
            fifo_wvalid <= 1'b0; fifo_wdata <= '0;
        end else begin
            rf_we        <= 1'b0;
            strobe_valid <= 1'b0;
            fifo_wvalid  <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
                tx_sr   <= '1;
            end else begin
                if ((state == ST_OFF || state == ST_WAIT) && core_ready) begin
                    tx_sr   <= status_byte;
                    bit_cnt <= '0;
                end
                if (active && sck_rise) begin
                    rx_sr   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    unique case (state)
                        ST_HDR: begin
                            addr_q  <= h_addr;
                            burst_q <= h_burst;
                            stat_q  <= h_burst && h_cmdwin;
                            if (!h_burst && h_cmdwin) begin
                                strobe_valid <= 1'b1;
                                strobe_addr  <= h_addr;
                                tx_next      <= status_byte;
                            end else begin
                                tx_next <= h_rw ? rd_val : status_byte;
                            end
                        end
                        ST_WR: begin
                            tx_next <= status_byte;
                            if (!stat_q && addr_q <= CFG_LAST) begin
                                rf_we    <= 1'b1;
                                rf_waddr <= addr_q;
                                rf_wdata <= rx_byte;
                            end
                            if (addr_q == QUEUE_ADR) begin
                                fifo_wvalid <= 1'b1;
                                fifo_wdata  <= rx_byte;
                            end else if (cont_burst) begin
                                addr_q <= addr_q + 1'b1;
                            end
                        end
                        ST_RD: begin
                            addr_q  <= addr_q + 1'b1;
                            tx_next <= cont_burst ? rd_val : status_byte;
                        end
                        default: ;
                    endcase
                end
                if (active && sck_fall)
                    tx_sr <= (bit_cnt == 3'd0) ? tx_next : {tx_sr[6:0], 1'b1};
            end
        end
    end

    assign sdo    = tx_sr[7];
    assign sdo_en = ~cs_s;
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo_en,
    input logic       strobe_valid,
    input logic [5:0] strobe_addr,
    input logic       fifo_wvalid,
    input logic       reg_we,
    input logic [5:0] reg_waddr
);
    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 1'b1;
    end

    // R5
    strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_valid |-> (strobe_addr >= 6'h30 && strobe_addr <= 6'h3D));
    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_valid |=> !strobe_valid);
    // R9
    fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wvalid |=> !fifo_wvalid);
    // R9
    fifo_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_wvalid && strobe_valid));
    // R2
    reg_waddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_waddr <= 6'h2E);
    // R8
    sdo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 3 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);
endmodule

bind spi_cfg_slave spi_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en),
    .strobe_valid(strobe_valid), .strobe_addr(strobe_addr),
    .fifo_wvalid(fifo_wvalid), .reg_we(rf_we), .reg_waddr(rf_waddr)
);

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;
    localparam int HALF = 8;
    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, sdi = 0;
    logic core_ready = 1;
    logic [2:0] radio_mode = 3'b011;
    logic [3:0] fifo_room = 4'h9;
    logic sdo, sdo_en, strobe_valid, fifo_wvalid;
    logic [3:0] stat_addr;
    logic [7:0] stat_rdata, fifo_wdata;
    logic [5:0] strobe_addr;
    int errors = 0, checks = 0, r10_bad = 0;
    int strobe_cnt = 0, fifo_cnt = 0;
    logic [5:0] strobe_last = '0;
    logic [7:0] fifo_last = '0;

    always #5 clk = ~clk;
    assign stat_rdata = 8'hA0 | {4'h0, stat_addr};

    spi_cfg_slave dut (.*);

    always @(posedge clk) begin
        if (strobe_valid) begin strobe_cnt <= strobe_cnt + 1; strobe_last <= strobe_addr; end
        if (fifo_wvalid)  begin fifo_cnt <= fifo_cnt + 1;   fifo_last <= fifo_wdata;   end
    end

    localparam logic [13:0] VEC [6] = '{
        {6'h00, 8'h5A}, {6'h01, 8'hC3}, {6'h10, 8'hFF},
        {6'h1F, 8'h01}, {6'h2A, 8'h80}, {6'h2E, 8'h7E}};

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sdi = tx[i];
            wclk(HALF);
            rx[i] = sdo;
            sck = 1;
            wclk(HALF);
            if (sdo !== rx[i]) r10_bad++;
            sck = 0;
        end
    endtask

    task automatic sel(); cs_n = 0; wclk(HALF); endtask
    task automatic desel(); cs_n = 1; wclk(HALF); endtask

    function automatic logic [7:0] stat_exp();
        return {~core_ready, radio_mode, fifo_room};
    endfunction

    task automatic wr1(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] s0, s1;
        sel(); xbyte({2'b00, a}, s0); xbyte(d, s1); desel();
        chk(s0 == stat_exp() && s1 == stat_exp(), "R7 write status", {s0, s1}, {stat_exp(), stat_exp()});
    endtask

    task automatic rd1(input logic [5:0] a, output logic [7:0] d);
        logic [7:0] s0;
        sel(); xbyte({2'b10, a}, s0); xbyte(8'h00, d); desel();
        chk(s0 == stat_exp(), "R7 read header status", s0, stat_exp());
    endtask

    initial begin
        logic [7:0] r, s;
        int sc, fc;
        wclk(5);
        chk(sdo_en == 0 && strobe_valid == 0 && fifo_wvalid == 0, "R8 reset idle", sdo_en, 0);
        rst_n = 1; wclk(5);
        // R2 reset value
        rd1(6'h05, r); chk(r == 8'h00, "R2 reset value", r, 0);
        // R1 R2 table walk
        foreach (VEC[i]) wr1(VEC[i][13:8], VEC[i][7:0]);
        foreach (VEC[i]) begin
            rd1(VEC[i][13:8], r);
            chk(r == VEC[i][7:0], "R1 R2 readback", r, VEC[i][7:0]);
        end
        // R2 unimplemented
        rd1(6'h3E, r); chk(r == 8'h00, "R2 unimplemented 0x3E", r, 0);
        wr1(6'h2F, 8'h99); rd1(6'h2F, r); chk(r == 8'h00, "R2 write 0x2F ignored", r, 0);
        // R3 burst write/read across end of file
        sel(); xbyte(8'h6D, s); xbyte(8'h11, s); xbyte(8'h22, s); xbyte(8'h33, s); desel();
        sel(); xbyte(8'hED, s);
        xbyte(8'h00, r); chk(r == 8'h11, "R3 burst rd 0", r, 8'h11);
        xbyte(8'h00, r); chk(r == 8'h22, "R3 burst rd 1", r, 8'h22);
        xbyte(8'h00, r); chk(r == 8'h00, "R3 burst rd 2", r, 0);
        desel();
        // R3 single access: second byte is a new header
        sel(); xbyte(8'h03, s); xbyte(8'h44, s); xbyte(8'h84, s); xbyte(8'h00, r); desel();
        chk(r == 8'h00, "R3 single then header read 0x04", r, 0);
        rd1(6'h03, r); chk(r == 8'h44, "R3 single write", r, 8'h44);
        // R4 cancel
        sel(); xbyte(8'h01, s);
        for (int i = 7; i >= 4; i--) begin
            sdi = 1'b0; wclk(HALF); sck = 1; wclk(HALF); sck = 0;
        end
        desel();
        rd1(6'h01, r); chk(r == 8'hC3, "R4 cancelled byte", r, 8'hC3);
        // R5 strobe then read in same selection
        sc = strobe_cnt;
        sel(); xbyte(8'h36, s);
        chk(s == stat_exp(), "R5 strobe header status", s, stat_exp());
        xbyte(8'h81, s); xbyte(8'h00, r); desel();
        chk(strobe_cnt == sc + 1 && strobe_last == 6'h36, "R5 strobe", strobe_last, 6'h36);
        chk(r == 8'hC3, "R5 access after strobe", r, 8'hC3);
        // R6 status read and ignored write
        sel(); xbyte(8'hF4, s); xbyte(8'h00, r); xbyte(8'h81, s); xbyte(8'h00, s); desel();
        chk(r == 8'hA4, "R6 status read", r, 8'hA4);
        chk(s == 8'hC3, "R6 single then header", s, 8'hC3);
        sc = strobe_cnt; fc = fifo_cnt;
        sel(); xbyte(8'h74, s); xbyte(8'h5A, s); desel();
        chk(strobe_cnt == sc && fifo_cnt == fc, "R6 status write ignored", strobe_cnt, sc);
        rd1(6'h04, r); chk(r == 8'h00, "R6 no alias write", r, 0);
        // R9 queue single and burst
        fc = fifo_cnt;
        sel(); xbyte(8'h3F, s); xbyte(8'hAA, s); desel();
        chk(fifo_cnt == fc + 1 && fifo_last == 8'hAA, "R9 single push", fifo_last, 8'hAA);
        fifo_room = 4'hF;
        sel(); xbyte(8'h7F, s); xbyte(8'h01, s); xbyte(8'h02, s); xbyte(8'h03, r); desel();
        chk(fifo_cnt == fc + 4 && fifo_last == 8'h03, "R9 burst push", fifo_cnt, fc + 4);
        chk(r == 8'h3F, "R7 status during queue data", r, 8'h3F);
        rd1(6'h00, r); chk(r == 8'h5A, "R9 no address advance", r, 8'h5A);
        // R8 ready handling
        core_ready = 0;
        cs_n = 0; wclk(HALF);
        chk(sdo_en == 1 && sdo == 1, "R8 waiting high", sdo, 1);
        core_ready = 1; wclk(HALF);
        chk(sdo == 0, "R8 ready bit low", sdo, 0);
        desel();
        chk(sdo_en == 0, "R8 released", sdo_en, 0);
        // R10
        chk(r10_bad == 0, "R10 sdo stable while sck high", r10_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule